// File: doc/BRIEF.md
# Dimension-Order Mesh Route Unit

This block computes the output direction for one router of a two-dimensional mesh that routes in dimension order, X before Y. Each head flit carries two signed hop counts, one for X and one for Y. The block chooses one of five directions: west, east, south, north, or the local node. It then moves the hop count it consumed one step toward zero, so the next router sees the remaining distance. Movement in Y starts only once the X count has reached zero.

The direction decided on the head flit is kept for the body and tail flits of the same packet, and those flits add no further decision delay. The route is dropped when the tail flit leaves. Flits enter and leave through a valid/ready handshake. A single output register holds the flit and its direction while the downstream side stalls. The crossbar, output arbitration, virtual channels and adaptive selection belong to neighbouring blocks.

Top module: `mesh_dor_route`

## Requirements
- R1: After reset, out_valid_o is 0, out_port_o is 0 and in_ready_o is 1.
- R2: Flit layout for the default build:
  - bits [4:0] hold the X count and bits [9:5] hold the Y count, both in two's complement.
  - bits [15:14] hold the type: 01 head, 00 body, 10 tail, 11 single-flit packet (head and tail at once).
  - All bits other than the rewritten count pass through unchanged.
- R3: On a head flit whose X count is negative, the unit selects west (out_port_o bit 0) and forwards the X count plus one.
- R4: On a head flit whose X count is positive, the unit selects east (bit 1) and forwards the X count minus one. The Y count is left unchanged.
- R5: On a head flit whose X count is zero, the Y count decides the direction:
  - a negative Y count selects south (bit 2) and forwards the Y count plus one;
  - a positive Y count selects north (bit 3) and forwards the Y count minus one.
- R6: On a head flit whose X and Y counts are both zero, the unit selects the local port (bit 4) and leaves the header unchanged.
- R7: Body and tail flits leave unmodified on the direction chosen by their head. After a tail or single flit the route is cleared, so a body flit arriving with no head leaves with out_port_o equal to 0.
- R8: While out_valid_o is 1 and out_ready_i is 0, out_flit_o and out_port_o hold their values and in_ready_o is 0. Each flit leaves exactly once.
- R9: An accepted flit appears at the output in the next cycle. With out_ready_i held at 1, one flit per cycle passes.
- R10: out_port_o is 0 whenever out_valid_o is 0, and has at most one bit set otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input flit valid |
| in_ready_o | output | 1 | Unit can take a flit |
| in_flit_i | input | FLIT_W | Incoming flit |
| out_valid_o | output | 1 | Output flit valid |
| out_ready_i | input | 1 | Downstream takes the flit |
| out_flit_o | output | FLIT_W | Outgoing flit, header rewritten on head flits |
| out_port_o | output | 5 | One-hot direction {local, north, south, east, west} |

## Verification
The bench builds the unit with its defaults: 5-bit hop counts in a 16-bit flit. At that size all 1024 pairs of X and Y counts can be sent as full head/body/tail packets. This covers both extreme counts, -16 and +15, and every zero and non-zero boundary that decides between the two dimensions. Stall lengths vary from packet to packet. Separate sequences cover back-to-back streaming, single-flit packets, and a body flit that arrives after the route has been cleared.

// File: rtl/dor_pkg.sv
package dor_pkg;
  typedef enum logic [1:0] {
    FT_BODY   = 2'b00,
    FT_HEAD   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } flit_type_e;

  localparam int NUM_DIRS = 5;
  localparam int DIR_WEST  = 0;
  localparam int DIR_EAST  = 1;
  localparam int DIR_SOUTH = 2;
  localparam int DIR_NORTH = 3;
  localparam int DIR_LOCAL = 4;
endpackage

// File: rtl/dor_decide.sv
module dor_decide
  import dor_pkg::*;
#(
  parameter int OFF_W = 5
) (
  input  logic [OFF_W-1:0]    dx_i,
  input  logic [OFF_W-1:0]    dy_i,
  output logic [NUM_DIRS-1:0] dir_o,
  output logic [OFF_W-1:0]    dx_o,
  output logic [OFF_W-1:0]    dy_o
);
  localparam logic [OFF_W-1:0] ONE = {{(OFF_W-1){1'b0}}, 1'b1};

  logic dx_neg, dx_zero, dy_neg, dy_zero;

  assign dx_neg  = dx_i[OFF_W-1];
  assign dy_neg  = dy_i[OFF_W-1];
  assign dx_zero = (dx_i == '0);
  assign dy_zero = (dy_i == '0);

  always_comb begin
    dir_o = '0;
    dx_o  = dx_i;
    dy_o  = dy_i;
    if (!dx_zero) begin
      // X is always resolved first
      if (dx_neg) begin
        dir_o[DIR_WEST] = 1'b1;
        dx_o = dx_i + ONE;
      end else begin
        dir_o[DIR_EAST] = 1'b1;
        dx_o = dx_i - ONE;
      end
    end else if (!dy_zero) begin
      if (dy_neg) begin
        dir_o[DIR_SOUTH] = 1'b1;
        dy_o = dy_i + ONE;
      end else begin
        dir_o[DIR_NORTH] = 1'b1;
        dy_o = dy_i - ONE;
      end
    end else begin
      dir_o[DIR_LOCAL] = 1'b1;
    end
  end
endmodule

// File: rtl/dor_route_hold.sv
module dor_route_hold
  import dor_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic                is_head_i,
  input  logic                is_tail_i,
  input  logic [NUM_DIRS-1:0] head_dir_i,
  output logic [NUM_DIRS-1:0] dir_o
);
  logic [NUM_DIRS-1:0] route_q;

  // head flits use the fresh decision, others the held one
  assign dir_o = is_head_i ? head_dir_i : route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
    end else if (accept_i) begin
      if (is_tail_i)      route_q <= '0;
      else if (is_head_i) route_q <= head_dir_i;
    end
  end
endmodule

// File: rtl/dor_out_stage.sv
module dor_out_stage #(
  parameter int DATA_W = 16,
  parameter int DIR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] flit_i,
  input  logic [DIR_W-1:0]  dir_i,
  input  logic              ready_i,
  output logic              free_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] flit_o,
  output logic [DIR_W-1:0]  dir_o
);
  logic              valid_q;
  logic [DATA_W-1:0] flit_q;
  logic [DIR_W-1:0]  dir_q;

  assign free_o  = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign flit_o  = flit_q;
  assign dir_o   = valid_q ? dir_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      flit_q  <= '0;
      dir_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      flit_q  <= flit_i;
      dir_q   <= dir_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mesh_dor_route.sv
module mesh_dor_route
  import dor_pkg::*;
#(
  parameter int OFF_W  = 5,
  parameter int FLIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [FLIT_W-1:0] in_flit_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [FLIT_W-1:0] out_flit_o,
  output logic [4:0]        out_port_o
);
  localparam int DX_LO = 0;
  localparam int DY_LO = OFF_W;
  localparam int TY_LO = FLIT_W - 2;

  logic [1:0]          ftype;
  logic                is_head, is_tail, accept, free;
  logic [OFF_W-1:0]    dx_in, dy_in, dx_nx, dy_nx;
  logic [NUM_DIRS-1:0] head_dir, sel_dir;
  logic [FLIT_W-1:0]   flit_nx;

  assign ftype   = in_flit_i[TY_LO +: 2];
  assign is_head = (ftype == FT_HEAD) || (ftype == FT_SINGLE);
  assign is_tail = (ftype == FT_TAIL) || (ftype == FT_SINGLE);
  assign dx_in   = in_flit_i[DX_LO +: OFF_W];
  assign dy_in   = in_flit_i[DY_LO +: OFF_W];
  assign accept  = in_valid_i && free;
  assign in_ready_o = free;

  dor_decide #(.OFF_W(OFF_W)) i_decide (
    .dx_i (dx_in),
    .dy_i (dy_in),
    .dir_o(head_dir),
    .dx_o (dx_nx),
    .dy_o (dy_nx)
  );

  dor_route_hold i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .is_head_i (is_head),
    .is_tail_i (is_tail),
    .head_dir_i(head_dir),
    .dir_o     (sel_dir)
  );

  always_comb begin
    flit_nx = in_flit_i;
    if (is_head) begin
      flit_nx[DX_LO +: OFF_W] = dx_nx;
      flit_nx[DY_LO +: OFF_W] = dy_nx;
    end
  end

  dor_out_stage #(.DATA_W(FLIT_W), .DIR_W(NUM_DIRS)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .flit_i (flit_nx),
    .dir_i  (sel_dir),
    .ready_i(out_ready_i),
    .free_o (free),
    .valid_o(out_valid_o),
    .flit_o (out_flit_o),
    .dir_o  (out_port_o)
  );
endmodule

// File: rtl/mesh_dor_route_chk.sv
module mesh_dor_route_chk #(
  parameter int OFF_W  = 5,
  parameter int FLIT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [FLIT_W-1:0] out_flit_o,
  input logic [4:0]        out_port_o
);
  logic out_head;
  assign out_head = out_flit_o[FLIT_W-2 +: 2] == 2'b01 || out_flit_o[FLIT_W-2 +: 2] == 2'b11;

  AST_IDLE_NO_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> out_port_o == '0); // R10
  AST_PORT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $onehot0(out_port_o)); // R10
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_flit_o) && $stable(out_port_o)); // R8
  AST_STALL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R9
  AST_Y_AFTER_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_head && (out_port_o[3] || out_port_o[2]) |-> out_flit_o[OFF_W-1:0] == '0); // R5
  AST_LOCAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_head && out_port_o[4] |-> out_flit_o[2*OFF_W-1:0] == '0); // R6
endmodule

bind mesh_dor_route mesh_dor_route_chk #(.OFF_W(OFF_W), .FLIT_W(FLIT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_flit_o (out_flit_o),
  .out_port_o (out_port_o)
);

// File: tb/test_mesh_dor_route.sv
module test_mesh_dor_route;
  localparam int OFF_W = 5;
  localparam int FLIT_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [FLIT_W-1:0] in_flit_i = '0;
  logic out_valid_o;
  logic out_ready_i = 1'b0;
  logic [FLIT_W-1:0] out_flit_o;
  logic [4:0] out_port_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  mesh_dor_route #(.OFF_W(OFF_W), .FLIT_W(FLIT_W)) i_mesh_dor_route (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int t, input int pay, input int dy, input int dx);
    mk = {t[1:0], pay[3:0], dy[4:0], dx[4:0]};
  endfunction

  // one flit, checked at output, then held for stall cycles, then popped
  task automatic xfer(input logic [15:0] f, input logic [15:0] ef, input logic [4:0] ep,
                      input int stall, input string req);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_flit_i = f; out_ready_i = 1'b0;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(out_valid_o == 1'b1, "R9", "valid next cycle", int'(out_valid_o), 1);
    chk(out_flit_o == ef, req, "flit", int'(out_flit_o), int'(ef));
    chk(out_port_o == ep, req, "port", int'(out_port_o), int'(ep));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk_i);
      chk(out_flit_o == ef && out_port_o == ep && out_valid_o, "R8", "held",
          int'(out_flit_o), int'(ef));
      chk(in_ready_o == 1'b0, "R8", "ready low in stall", int'(in_ready_o), 0);
    end
    out_ready_i = 1'b1;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    chk(out_valid_o == 1'b0, "R8", "no duplicate", int'(out_valid_o), 0);
    chk(out_port_o == 5'd0, "R10", "idle port", int'(out_port_o), 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] ep;
    int ndx, ndy;
    string rq;
    #35;
    chk(out_valid_o == 1'b0 && out_port_o == 5'd0, "R1", "reset outputs", int'(out_port_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1", "ready after reset", int'(in_ready_o), 1);
    chk(out_valid_o == 1'b0, "R1", "valid after reset", int'(out_valid_o), 0);

    // R2..R7 exhaustive sweep of count pairs
    for (int dx = -16; dx < 16; dx++) begin
      for (int dy = -16; dy < 16; dy++) begin
        ndx = dx; ndy = dy;
        if (dx < 0)      begin ep = 5'b00001; ndx = dx + 1; rq = "R3"; end
        else if (dx > 0) begin ep = 5'b00010; ndx = dx - 1; rq = "R4"; end
        else if (dy < 0) begin ep = 5'b00100; ndy = dy + 1; rq = "R5"; end
        else if (dy > 0) begin ep = 5'b01000; ndy = dy - 1; rq = "R5"; end
        else             begin ep = 5'b10000; rq = "R6"; end
        xfer(mk(1, dx + dy, dy, dx), mk(1, dx + dy, ndy, ndx), ep, (dx - dy) & 3, rq);
        xfer(mk(0, 5, dy + 3, dx), mk(0, 5, dy + 3, dx), ep, 0, "R7");
        xfer(mk(2, 9, dy, dx + 7), mk(2, 9, dy, dx + 7), ep, 1, "R2");
      end
    end

    // R7: route cleared after tail
    xfer(mk(0, 3, 4, 4), mk(0, 3, 4, 4), 5'b00000, 0, "R7");
    // single-flit packet then stray body
    xfer(mk(3, 1, 3, 0), mk(3, 1, 2, 0), 5'b01000, 2, "R5");
    xfer(mk(0, 1, 1, 1), mk(0, 1, 1, 1), 5'b00000, 0, "R7");

    // R9: streaming, one flit per cycle
    @(negedge clk_i);
    out_ready_i = 1'b1;
    in_valid_i = 1'b1; in_flit_i = mk(1, 6, 0, 2);
    @(negedge clk_i);
    chk(out_flit_o == mk(1, 6, 0, 1) && out_port_o == 5'b00010, "R9", "stream head",
        int'(out_flit_o), int'(mk(1, 6, 0, 1)));
    for (int k = 0; k < 3; k++) begin
      in_flit_i = mk(k == 2 ? 2 : 0, k, k, k);
      @(negedge clk_i);
      chk(out_valid_o && out_flit_o == mk(k == 2 ? 2 : 0, k, k, k) && out_port_o == 5'b00010,
          "R9", "stream body/tail", int'(out_flit_o), int'(mk(k == 2 ? 2 : 0, k, k, k)));
    end
    in_valid_i = 1'b0;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R9", "stream drained", int'(out_valid_o), 0);
    out_ready_i = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule